// File: doc/BRIEF.md
# Memory word trap-bit checker

This block is a small tagged memory in which every word carries two user tag bits, U and V, next to its data. Each load or store arrives with a four-condition trap mask and an update code for each tag bit. In a single read-modify-write step the block reads the word's tags and tests them against the mask. If no enabled condition matches, it completes the access and rewrites the tags. If any condition matches, it leaves both data and tags untouched and raises a trap event for the local event queue.

The reported tag state is the pair {V,U}: 00 means available, 01 unavailable, 10 trap and 11 busy. This encoding lets software build word locks directly. An acquire is a load that traps on U high or on V high and sets U. A release is a store that traps on V high and clears U. The check and the tag update share one clock edge, so a request always sees the tags left by the request before it.

Top module: `tagtrap_unit`

## Requirements
- R1: After reset, rsp_valid and evt_valid are low, and every word holds data 0 with tags {V,U}=00.
- R2: An access traps exactly when an enabled mask condition holds on the tags before the access. The mask bits are: bit 0 traps on U=1, bit 1 on U=0, bit 2 on V=1 and bit 3 on V=0. A zero mask never traps.
- R3: A non-trapping access rewrites each tag bit from its own 2-bit code: 01 sets it, 10 clears it, and 00 or 11 keeps it.
- R4: A trapping access leaves the word's data and both tag bits unchanged.
- R5: A load, or a store that does not trap, returns the word's data from before the access on rsp_rdata. A store that does not trap writes req_wdata into the word.
- R6: Every request taken while req_valid is high gets exactly one response, with rsp_valid high, on the next cycle. rsp_trap reports whether that request trapped.
- R7: evt_valid is high exactly when the response is a trap. The event then carries the address, the operation (1 = store) and the tags from before the access.
- R8: rsp_tags reports the tags from before the access as {V,U}, with the encoding 00 available, 01 unavailable, 10 trap, 11 busy.
- R9: Two acquires to the same free word in back-to-back cycles resolve as follows: the first succeeds and the second traps, because it sees U already set.
- R10: A release (a store that traps on V high and clears U) frees a held word. When V is set, the release traps and leaves the word held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| req_trap_mask | input | 4 | Trap conditions: U high, U low, V high, V low (bits 0..3) |
| req_u_op | input | 2 | U update code |
| req_v_op | input | 2 | V update code |
| rsp_valid | output | 1 | Response present |
| rsp_trap | output | 1 | Access trapped |
| rsp_rdata | output | DATA_W | Word data before the access |
| rsp_tags | output | 2 | Tags {V,U} before the access |
| evt_valid | output | 1 | Trap event for the event queue |
| evt_addr | output | ADDR_W | Address of the trapping access |
| evt_write | output | 1 | Operation of the trapping access |
| evt_tags | output | 2 | Tags {V,U} seen by the trapping access |

## Verification
The assertions check on every cycle that:
- a response follows each request after exactly one cycle;
- an event appears only together with a trapping response and carries the same tags;
- the trap outcome agrees with the mask that was sampled against the reported tags.

Some behaviour can only be shown by the bench's scenarios, which read words back after the fact. These include that a trap leaves data and tags untouched, the effect of each update code, the lock acquire and release sequences, and the back-to-back acquire race.

// File: rtl/tagtrap_pkg.sv
package tagtrap_pkg;

    typedef enum logic [1:0] {
        TAG_KEEP  = 2'b00,
        TAG_SET   = 2'b01,
        TAG_CLEAR = 2'b10,
        TAG_KEEP2 = 2'b11
    } tag_op_e;

    typedef struct packed {
        logic v;
        logic u;
    } tag_pair_t;

    localparam int MASK_W = 4;

    function automatic logic apply_op(input logic cur, input tag_op_e op);
        case (op)
            TAG_SET:   apply_op = 1'b1;
            TAG_CLEAR: apply_op = 1'b0;
            default:   apply_op = cur;
        endcase
    endfunction

    function automatic logic [MASK_W-1:0] cond_vector(input tag_pair_t t);
        cond_vector = {~t.v, t.v, ~t.u, t.u};
    endfunction

endpackage

// File: rtl/tagtrap_store.sv
module tagtrap_store
    import tagtrap_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output tag_pair_t         rd_tags,
    input  logic              wr_data_en,
    input  logic              wr_tag_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  tag_pair_t         wr_tags
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] data_q [DEPTH];
    tag_pair_t         tag_q  [DEPTH];

    assign rd_data = data_q[rd_addr];
    assign rd_tags = tag_q[rd_addr];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                data_q[i] <= '0;
                tag_q[i]  <= '0;
            end else if (wr_addr == ADDR_W'(i)) begin
                if (wr_data_en) data_q[i] <= wr_data;
                if (wr_tag_en)  tag_q[i]  <= wr_tags;
            end
        end
    end
endmodule

// File: rtl/tagtrap_eval.sv
module tagtrap_eval
    import tagtrap_pkg::*;
(
    input  tag_pair_t         cur_tags,
    input  logic [MASK_W-1:0] trap_mask,
    input  tag_op_e           u_op,
    input  tag_op_e           v_op,
    output logic              trap,
    output tag_pair_t         next_tags
);
    always_comb begin
        trap        = |(trap_mask & cond_vector(cur_tags));
        next_tags.u = apply_op(cur_tags.u, u_op);
        next_tags.v = apply_op(cur_tags.v, v_op);
    end
endmodule

// File: rtl/tagtrap_unit.sv
module tagtrap_unit
    import tagtrap_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [3:0]        req_trap_mask,
    input  logic [1:0]        req_u_op,
    input  logic [1:0]        req_v_op,
    output logic              rsp_valid,
    output logic              rsp_trap,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [1:0]        rsp_tags,
    output logic              evt_valid,
    output logic [ADDR_W-1:0] evt_addr,
    output logic              evt_write,
    output logic [1:0]        evt_tags
);
    logic [DATA_W-1:0] cur_data;
    tag_pair_t         cur_tags;
    tag_pair_t         new_tags;
    logic              hit_trap;
    logic              commit;

    tagtrap_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .rd_addr    (req_addr),
        .rd_data    (cur_data),
        .rd_tags    (cur_tags),
        .wr_data_en (commit & req_write),
        .wr_tag_en  (commit),
        .wr_addr    (req_addr),
        .wr_data    (req_wdata),
        .wr_tags    (new_tags)
    );

    tagtrap_eval u_eval (
        .cur_tags  (cur_tags),
        .trap_mask (req_trap_mask),
        .u_op      (tag_op_e'(req_u_op)),
        .v_op      (tag_op_e'(req_v_op)),
        .trap      (hit_trap),
        .next_tags (new_tags)
    );

    assign commit = req_valid & ~hit_trap;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_trap  <= 1'b0;
            rsp_rdata <= '0;
            rsp_tags  <= '0;
            evt_valid <= 1'b0;
            evt_addr  <= '0;
            evt_write <= 1'b0;
            evt_tags  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_trap  <= req_valid & hit_trap;
            evt_valid <= req_valid & hit_trap;
            if (req_valid) begin
                rsp_rdata <= cur_data;
                rsp_tags  <= cur_tags;
                evt_addr  <= req_addr;
                evt_write <= req_write;
                evt_tags  <= cur_tags;
            end
        end
    end
endmodule

// File: rtl/tagtrap_unit_chk.sv
module tagtrap_unit_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [3:0]        req_trap_mask,
    input logic              rsp_valid,
    input logic              rsp_trap,
    input logic [1:0]        rsp_tags,
    input logic              evt_valid,
    input logic [1:0]        evt_tags
);
    assert_rsp_follows_req_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R6: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_evt_with_trap_R7: assert property (@(posedge clk) disable iff (rst)
        evt_valid == (rsp_valid && rsp_trap));

    assert_evt_tags_R7: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> (evt_tags == rsp_tags));

    assert_trap_decision_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_trap == |($past(req_trap_mask) &
            {~rsp_tags[1], rsp_tags[1], ~rsp_tags[0], rsp_tags[0]})));
endmodule

bind tagtrap_unit tagtrap_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_trap_mask (req_trap_mask),
    .rsp_valid     (rsp_valid),
    .rsp_trap      (rsp_trap),
    .rsp_tags      (rsp_tags),
    .evt_valid     (evt_valid),
    .evt_tags      (evt_tags)
);

// File: tb/tagtrap_unit_bench.sv
module tagtrap_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam int NW = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [3:0] req_trap_mask = '0;
    logic [1:0] req_u_op = '0, req_v_op = '0;
    logic rsp_valid, rsp_trap, evt_valid, evt_write;
    logic [DW-1:0] rsp_rdata;
    logic [1:0] rsp_tags, evt_tags;
    logic [AW-1:0] evt_addr;

    int checks = 0;
    int failures = 0;

    // behavioural reference state
    int m_data [NW];
    bit m_u [NW];
    bit m_v [NW];
    bit e_valid, e_trap, e_write;
    int e_data;
    bit [1:0] e_tags;
    bit [AW-1:0] e_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    tagtrap_unit #(.ADDR_W(AW), .DATA_W(DW)) u_tagtrap_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_trap_mask(req_trap_mask),
        .req_u_op(req_u_op), .req_v_op(req_v_op), .rsp_valid(rsp_valid),
        .rsp_trap(rsp_trap), .rsp_rdata(rsp_rdata), .rsp_tags(rsp_tags),
        .evt_valid(evt_valid), .evt_addr(evt_addr), .evt_write(evt_write),
        .evt_tags(evt_tags)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check({tag, " rsp_valid"}, 64'(rsp_valid), 64'(e_valid));
        check({tag, " evt_valid"}, 64'(evt_valid), 64'(e_valid && e_trap));
        if (e_valid) begin
            check({tag, " rsp_trap"}, 64'(rsp_trap), 64'(e_trap));
            check({tag, " rsp_rdata"}, 64'(rsp_rdata), 64'(e_data));
            check({tag, " rsp_tags"}, 64'(rsp_tags), 64'(e_tags));
            if (e_trap) begin
                check({tag, " evt_addr"}, 64'(evt_addr), 64'(e_addr));
                check({tag, " evt_write"}, 64'(evt_write), 64'(e_write));
                check({tag, " evt_tags"}, 64'(evt_tags), 64'(e_tags));
            end
        end
    endtask

    function automatic bit upd(bit cur, bit [1:0] op);
        if (op == 2'b01) return 1'b1;
        if (op == 2'b10) return 1'b0;
        return cur;
    endfunction

    task automatic access(input string tag, input bit wr, input int a, input int wd,
                          input bit [3:0] mask, input bit [1:0] uop, input bit [1:0] vop);
        bit u, v, tr;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = wd;
        req_trap_mask = mask; req_u_op = uop; req_v_op = vop;
        u = m_u[a]; v = m_v[a];
        tr = (mask[0] && u) || (mask[1] && !u) || (mask[2] && v) || (mask[3] && !v);
        e_valid = 1; e_trap = tr; e_data = m_data[a]; e_tags = {v, u};
        e_addr = AW'(a); e_write = wr;
        if (!tr) begin
            if (wr) m_data[a] = wd;
            m_u[a] = upd(u, uop);
            m_v[a] = upd(v, vop);
        end
        @(posedge clk); #1;
        compare(tag);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        req_valid = 1'b0;
        e_valid = 0; e_trap = 0;
        @(posedge clk); #1;
        compare(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) begin m_data[i] = 0; m_u[i] = 0; m_v[i] = 0; end
        e_valid = 0; e_trap = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1 compare("R1 idle after reset");
        // R1: reset contents, read without disturbing tags
        access("R1 word0 reset", 0, 0, 0, 4'h0, 2'b00, 2'b00);
        access("R1 word15 reset", 0, 15, 0, 4'h0, 2'b00, 2'b00);
        // R5: store then load
        access("R5 store", 1, 3, 32'h1234abcd, 4'h0, 2'b00, 2'b00);
        access("R5 load back", 0, 3, 0, 4'h0, 2'b00, 2'b00);
        // R3: update codes
        access("R3 set U", 0, 4, 0, 4'h0, 2'b01, 2'b00);
        access("R3 set V keep U code11", 0, 4, 0, 4'h0, 2'b11, 2'b01);
        access("R8 busy state 11", 0, 4, 0, 4'h0, 2'b10, 2'b00);
        access("R8 trap state 10", 0, 4, 0, 4'h0, 2'b00, 2'b10);
        access("R3 cleared both", 0, 4, 0, 4'h0, 2'b00, 2'b00);
        // R2: each condition in both states
        for (int b = 0; b < 4; b++) begin
            access("R2 single cond tags 00", 0, 5, 0, 4'(1 << b), 2'b00, 2'b00);
        end
        access("R2 prep tags 11", 0, 5, 0, 4'h0, 2'b01, 2'b01);
        for (int b = 0; b < 4; b++) begin
            access("R2 single cond tags 11", 0, 5, 0, 4'(1 << b), 2'b00, 2'b00);
        end
        // R4: trapping store leaves data and tags
        access("R4 trapping store", 1, 5, 32'hdeadbeef, 4'h1, 2'b10, 2'b10);
        access("R4 word intact", 0, 5, 0, 4'h0, 2'b00, 2'b00);
        idle("R6 no request no response");
        // R9: back-to-back acquires
        access("R9 first acquire", 0, 7, 0, 4'h5, 2'b01, 2'b00);
        access("R9 second acquire", 0, 7, 0, 4'h5, 2'b01, 2'b00);
        // R10: release, then release with V set
        access("R10 release", 1, 7, 32'h55, 4'h4, 2'b10, 2'b00);
        access("R10 reacquire", 0, 7, 0, 4'h5, 2'b01, 2'b00);
        access("R10 set V", 0, 7, 0, 4'h0, 2'b00, 2'b01);
        access("R10 release traps on V", 1, 7, 32'h66, 4'h4, 2'b10, 2'b00);
        access("R10 still held", 0, 7, 0, 4'h0, 2'b00, 2'b00);
        // R7: trap event fields on store to another word
        access("R7 store trap event", 1, 9, 32'h9, 4'h2, 2'b00, 2'b00);
        // mixed pattern
        for (int i = 0; i < 40; i++) begin
            access("R2 mixed", (i % 3) == 0, (i * 5) % NW, i * 77,
                   4'((i * 7) % 16), 2'((i / 2) % 4), 2'((i / 3) % 4));
        end
        idle("R6 final idle");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule